// File: doc/BRIEF.md
# Endpoint DMA Request Handshake Controller

This block connects the endpoint buffers of a USB device to an external DMA controller of the classic single-channel request/acknowledge kind. Software selects one endpoint as the DMA target, loads a byte count and sets an enable bit. The block then raises a request whenever that endpoint can accept or supply a byte. It moves bytes one per acknowledged cycle, either one at a time or in bursts of up to sixteen, and stops when the count runs out or the protocol engine reports a short or empty packet.

The transfer direction is not programmed on its own: it follows the direction bit of the selected endpoint. An OUT endpoint is read by the DMA engine, and an IN endpoint is written by it. While acknowledge is active, the endpoint that receives the data access is the DMA target, whatever endpoint the CPU has selected for its own I/O accesses. The active levels of the request and acknowledge pins are programmable.

Top module: `dma_hs_ctrl`

## Requirements
- R1: After reset the request pin is low, the end-of-transfer pulse is low, the config register reads 0x0180, and the count and status registers read 0.
- R2: Config bits [3:0] hold the endpoint code. Codes 0 and 1 never produce a request. Codes 2 through 15 may produce one.
- R3: Let d be the direction bit of the selected endpoint. With d=0 (OUT) a request needs the endpoint's data-available bit, and with d=1 (IN) it needs its space-available bit. The read indicator output equals the inverse of d.
- R4: While acknowledge is active, the access endpoint output equals the DMA endpoint code. Otherwise it equals the CPU-selected endpoint.
- R5: Config bits [5:4] pick the burst length: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 16. The request drops after the last acknowledged byte of a burst and rises again after exactly one idle cycle if the conditions still hold.
- R6: The count register (address 1) drops by one for each acknowledged byte. No request is raised while it is 0. When it reaches 0, the block gives a one-cycle end-of-transfer pulse, clears the enable bit (config bit 6), sets status bit 0 and drops the request.
- R7: While enable is set, a short-packet or empty-packet input pulse ends the transfer. It gives the end-of-transfer pulse, clears enable and sets status bit 1 (short) or status bit 2 (empty). While enable is clear, these inputs have no effect.
- R8: Config bit 7 gives the active level of the request pin and config bit 8 gives the active level of the acknowledge pin (1 means active high).
- R9: When config bit 9 is set, no request is raised.
- R10: Writing 1 to a status bit (address 2) clears it, and bits written with 0 are kept. A status bit set by an end-of-transfer in the same cycle as its clear stays set.
- R11: A count write in the same cycle as an acknowledged byte loads the written value. Reading the count register returns the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 config, 1 count, 2 status |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| cpu_ep_i | input | 4 | Endpoint the CPU has selected for I/O access |
| ep_dir_i | input | 16 | Direction bit per endpoint code (1 = IN) |
| ep_data_avail_i | input | 16 | Per-endpoint flag: buffer holds data |
| ep_space_avail_i | input | 16 | Per-endpoint flag: buffer has free space |
| short_pkt_i | input | 1 | Short packet seen on the DMA endpoint |
| empty_pkt_i | input | 1 | Empty packet seen on the DMA endpoint |
| dreq_o | output | 1 | DMA request pin, programmable level |
| dack_i | input | 1 | DMA acknowledge pin, programmable level |
| xfer_o | output | 1 | Byte moves on this clock edge |
| access_ep_o | output | 4 | Endpoint that receives the data access |
| dma_read_o | output | 1 | 1: DMA reads the endpoint (OUT); 0: DMA writes it (IN) |
| eot_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two functions can act on the same register in one cycle. First, an end-of-transfer can set a status bit in the same cycle that software writes 1 to clear it. The bench provokes this by pulsing the short-packet input during the status write and expects the bit to read back as set. Second, a count write can meet an acknowledged byte. The bench holds acknowledge during a request while writing the count, expects the written value rather than the decremented one, and then expects the next acknowledged byte to decrement from the written value.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned BL_W  = 5;
  localparam int unsigned CS_W  = 3;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_CNT  = 2'd1,
    A_STAT = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;

  // field order fixes the config word layout, bit 9 down to bit 0
  typedef struct packed {
    logic             mode_off;
    logic             ack_lvl;
    logic             req_lvl;
    logic             en;
    logic [1:0]       burst_sel;
    logic [IDX_W-1:0] ep_idx;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
  localparam cfg_t CFG_RST = '{mode_off: 1'b0, ack_lvl: 1'b1, req_lvl: 1'b1,
                               en: 1'b0, burst_sel: 2'd0, ep_idx: '0};

  function automatic logic [BL_W-1:0] burst_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return BL_W'(1);
      2'd1:    return BL_W'(4);
      2'd2:    return BL_W'(8);
      default: return BL_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/dma_hs_regs.sv
module dma_hs_regs
  import dma_hs_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             en_clr_i,
  input  logic [CS_W-1:0]  set_i,
  input  logic [CNT_W-1:0] cnt_i,
  output cfg_t             cfg_o,
  output logic             cnt_load_o,
  output logic [REG_W-1:0] rdata_o
);
  cfg_t            cfg_q;
  logic [CS_W-1:0] stat_q;
  logic [CS_W-1:0] clr;

  assign clr        = (we_i && addr_i == A_STAT) ? wdata_i[CS_W-1:0] : '0;
  assign cnt_load_o = we_i && addr_i == A_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      stat_q <= '0;
    end else begin
      if (we_i && addr_i == A_CFG) cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
      if (en_clr_i) cfg_q.en <= 1'b0;      // termination beats a write
      stat_q <= (stat_q & ~clr) | set_i;   // set beats write-1-clear
    end
  end

  always_comb begin
    case (addr_i)
      A_CFG:   rdata_o = REG_W'(cfg_q);
      A_CNT:   rdata_o = REG_W'(cnt_i);
      A_STAT:  rdata_o = REG_W'(stat_q);
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;

  assert_status_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  assert_en_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> !cfg_q.en);
endmodule

// File: rtl/dma_hs_engine.sv
module dma_hs_engine
  import dma_hs_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_off_i,
  input  logic [1:0]       burst_sel_i,
  input  logic             ep_valid_i,
  input  logic             ep_ready_i,
  input  logic             ack_i,
  input  logic             short_i,
  input  logic             empty_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic             req_o,
  output logic             xfer_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eot_o,
  output logic [CS_W-1:0]  cause_o,
  output logic             en_clr_o
);
  logic             req_q, eot_q;
  logic [BL_W-1:0]  burst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_nz, xfer, burst_end, term, start;
  logic             term_cnt, term_short, term_empty;

  assign cnt_nz     = cnt_q != '0;
  assign xfer       = req_q && ack_i && cnt_nz;
  assign burst_end  = xfer && burst_q == BL_W'(1);
  assign term_cnt   = xfer && cnt_q == CNT_W'(1) && !cnt_load_i;
  assign term_short = en_i && short_i;
  assign term_empty = en_i && empty_i;
  assign cause_o    = {term_empty, term_short, term_cnt};
  assign term       = |cause_o;
  assign start      = !req_q && en_i && !mode_off_i && ep_valid_i && ep_ready_i
                      && cnt_nz && !term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      burst_q <= '0;
      cnt_q   <= '0;
      eot_q   <= 1'b0;
    end else begin
      req_q <= start || (req_q && en_i && !burst_end && !term);
      if (start)     burst_q <= burst_len(burst_sel_i);
      else if (xfer) burst_q <= burst_q - BL_W'(1);
      if (cnt_load_i) cnt_q <= cnt_wdata_i;
      else if (xfer)  cnt_q <= cnt_q - CNT_W'(1);
      eot_q <= term;
    end
  end

  assign req_o    = req_q;
  assign xfer_o   = xfer;
  assign cnt_o    = cnt_q;
  assign eot_o    = eot_q;
  assign en_clr_o = term;

  assert_req_valid_ep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(ep_valid_i));

  assert_burst_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> burst_q != '0);

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && !cnt_load_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_eot_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_q |=> !eot_q);

  assert_req_drop_eot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_q |-> !req_q);
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned EP_N = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [IDX_W-1:0] cpu_ep_i,
  input  logic [EP_N-1:0]  ep_dir_i,
  input  logic [EP_N-1:0]  ep_data_avail_i,
  input  logic [EP_N-1:0]  ep_space_avail_i,
  input  logic             short_pkt_i,
  input  logic             empty_pkt_i,
  output logic             dreq_o,
  input  logic             dack_i,
  output logic             xfer_o,
  output logic [IDX_W-1:0] access_ep_o,
  output logic             dma_read_o,
  output logic             eot_o
);
  localparam logic [IDX_W-1:0] FIRST_EP_CODE = IDX_W'(2);

  cfg_t             cfg;
  logic             cnt_load, en_clr, req, ack_act, ep_dir, ep_valid, ep_ready;
  logic [CNT_W-1:0] cnt;
  logic [CS_W-1:0]  cause;

  dma_hs_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .en_clr_i   (en_clr),
    .set_i      (cause),
    .cnt_i      (cnt),
    .cfg_o      (cfg),
    .cnt_load_o (cnt_load),
    .rdata_o    (reg_rdata_o)
  );

  assign ack_act  = dack_i ~^ cfg.ack_lvl;
  assign ep_dir   = ep_dir_i[cfg.ep_idx];
  assign ep_valid = cfg.ep_idx >= FIRST_EP_CODE;
  assign ep_ready = ep_dir ? ep_space_avail_i[cfg.ep_idx] : ep_data_avail_i[cfg.ep_idx];

  dma_hs_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cfg.en),
    .mode_off_i  (cfg.mode_off),
    .burst_sel_i (cfg.burst_sel),
    .ep_valid_i  (ep_valid),
    .ep_ready_i  (ep_ready),
    .ack_i       (ack_act),
    .short_i     (short_pkt_i),
    .empty_i     (empty_pkt_i),
    .cnt_load_i  (cnt_load),
    .cnt_wdata_i (reg_wdata_i[CNT_W-1:0]),
    .req_o       (req),
    .xfer_o      (xfer_o),
    .cnt_o       (cnt),
    .eot_o       (eot_o),
    .cause_o     (cause),
    .en_clr_o    (en_clr)
  );

  assign dreq_o      = req ~^ cfg.req_lvl;
  assign dma_read_o  = ~ep_dir;
  assign access_ep_o = ack_act ? cfg.ep_idx : cpu_ep_i;

  assert_xfer_route_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> access_ep_o == cfg.ep_idx);
endmodule

// File: tb/tb_dma_hs_ctrl.sv
module tb_dma_hs_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        reg_we_i;
  logic [1:0]  reg_addr_i;
  logic [15:0] reg_wdata_i;
  logic [15:0] reg_rdata_o;
  logic [3:0]  cpu_ep_i;
  logic [15:0] ep_dir_i, ep_data_avail_i, ep_space_avail_i;
  logic        short_pkt_i, empty_pkt_i;
  logic        dreq_o, dack_i, xfer_o, dma_read_o, eot_o;
  logic [3:0]  access_ep_o;

  int n_chk = 0;
  int n_fail = 0;
  bit req_lvl = 1'b1;
  bit ack_lvl = 1'b1;

  always #5 clk_i = ~clk_i;

  dma_hs_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .cpu_ep_i(cpu_ep_i),
    .ep_dir_i(ep_dir_i), .ep_data_avail_i(ep_data_avail_i),
    .ep_space_avail_i(ep_space_avail_i), .short_pkt_i(short_pkt_i),
    .empty_pkt_i(empty_pkt_i), .dreq_o(dreq_o), .dack_i(dack_i), .xfer_o(xfer_o),
    .access_ep_o(access_ep_o), .dma_read_o(dma_read_o), .eot_o(eot_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkcfg(bit mo, bit al, bit rl, bit en, int bs, int idx);
    return {6'b0, mo, al, rl, en, 2'(bs), 4'(idx)};
  endfunction

  function automatic int exp_blen(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 16;
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit req_now();
    return dreq_o ~^ req_lvl;
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(int a, logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = 2'(a); reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    reg_addr_i = 2'(a);
    #1;
    v = int'(reg_rdata_o);
  endtask

  task automatic off(int idx);
    wr(0, mkcfg(0, ack_lvl, req_lvl, 0, 0, idx));
    tick();
  endtask

  task automatic set_ack(bit a);
    dack_i = a ~^ ack_lvl;
  endtask

  task automatic run_xfer(int idx, bit dir, int bsel, int cnt, bit rl, bit al);
    int bytes = 0, run = 0, idle = 0, eots = 0, rem, v;
    bit seen = 1'b0, done = 1'b0;
    req_lvl = rl; ack_lvl = al; set_ack(1'b0);
    ep_dir_i = '0; ep_dir_i[idx] = dir;
    ep_data_avail_i = '1; ep_space_avail_i = '1;
    wr(1, 16'(cnt));
    wr(0, mkcfg(0, al, rl, 1, bsel, idx));
    rem = cnt;
    for (int c = 0; c < 2000 && !done; c++) begin
      #1;
      if (eot_o) eots++;
      if (req_now()) begin
        if (run == 0 && seen) chk("R5 idle gap", idle, 1);
        run++; bytes++; idle = 0; set_ack(1'b1);
      end else begin
        if (run > 0) begin
          chk("R5 burst length", run, min2(exp_blen(bsel), rem));
          rem -= run; run = 0; seen = 1'b1;
        end
        idle++; set_ack(1'b0);
        if (eots > 0) done = 1'b1;
      end
      tick();
    end
    #1;
    chk("R6 bytes moved", bytes, cnt);
    chk("R6 eot seen once", eots, 1);
    chk("R6 eot one cycle", int'(eot_o), 0);
    chk("R6 request dropped", int'(req_now()), 0);
    rd(2, v); chk("R6 status count bit", v, 1);
    rd(0, v); chk("R6 enable cleared", v & 16'h40, 0);
    rd(1, v); chk("R11 remaining zero", v, 0);
    wr(2, 16'h1);
    rd(2, v); chk("R10 status cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    rst_ni = 1'b0; reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    cpu_ep_i = '0; ep_dir_i = '0; ep_data_avail_i = '0; ep_space_avail_i = '0;
    short_pkt_i = 1'b0; empty_pkt_i = 1'b0; dack_i = 1'b0;
    repeat (3) tick();
    rst_ni = 1'b1;
    #1;
    chk("R1 dreq low", int'(dreq_o), 0);
    chk("R1 eot low", int'(eot_o), 0);
    rd(0, v); chk("R1 config reset", v, 16'h0180);
    rd(1, v); chk("R1 count reset", v, 0);
    rd(2, v); chk("R1 status reset", v, 0);
    tick();

    // R2 endpoint code validity
    ep_data_avail_i = '1;
    wr(1, 16'd10);
    for (int code = 0; code < 2; code++) begin
      wr(0, mkcfg(0, 1, 1, 1, 0, code));
      tick(); tick(); #1;
      chk("R2 invalid code no request", int'(dreq_o), 0);
      off(code);
    end
    wr(0, mkcfg(0, 1, 1, 1, 0, 2)); tick(); #1;
    chk("R2 code 2 requests", int'(dreq_o), 1);
    off(2); #1; chk("R2 request off", int'(dreq_o), 0);
    wr(0, mkcfg(0, 1, 1, 1, 0, 15)); tick(); #1;
    chk("R2 code 15 requests", int'(dreq_o), 1);
    off(15);

    // R3 direction and readiness
    ep_dir_i = '0; ep_data_avail_i = '0; ep_space_avail_i = '1;
    wr(0, mkcfg(0, 1, 1, 1, 0, 5)); tick(); tick(); #1;
    chk("R3 OUT without data", int'(dreq_o), 0);
    chk("R3 OUT read indicator", int'(dma_read_o), 1);
    ep_data_avail_i[5] = 1'b1; tick(); tick(); #1;
    chk("R3 OUT with data", int'(dreq_o), 1);
    off(5);
    ep_dir_i[5] = 1'b1; ep_space_avail_i[5] = 1'b0; ep_data_avail_i = '1;
    wr(0, mkcfg(0, 1, 1, 1, 0, 5)); tick(); tick(); #1;
    chk("R3 IN without space", int'(dreq_o), 0);
    chk("R3 IN read indicator", int'(dma_read_o), 0);
    ep_space_avail_i[5] = 1'b1; tick(); tick(); #1;
    chk("R3 IN with space", int'(dreq_o), 1);
    off(5);

    // R4 access routing
    cpu_ep_i = 4'd9;
    #1; chk("R4 cpu endpoint routed", int'(access_ep_o), 9);
    dack_i = 1'b1; #1;
    chk("R4 ack routes dma endpoint", int'(access_ep_o), 5);
    dack_i = 1'b0; tick();

    // R8 programmable levels
    req_lvl = 1'b0; ack_lvl = 1'b0;
    wr(0, mkcfg(0, 0, 0, 0, 0, 5)); #1;
    chk("R8 idle request pin high", int'(dreq_o), 1);
    dack_i = 1'b0; #1;
    chk("R8 low ack active", int'(access_ep_o), 5);
    dack_i = 1'b1; #1;
    chk("R8 high ack inactive", int'(access_ep_o), 9);
    wr(0, mkcfg(0, 0, 0, 1, 0, 5)); tick(); #1;
    chk("R8 request pin driven low", int'(dreq_o), 0);
    off(5);
    req_lvl = 1'b1; ack_lvl = 1'b1;
    wr(0, mkcfg(0, 1, 1, 0, 0, 5)); dack_i = 1'b0;

    // R9 mode bit blocks requests
    wr(0, mkcfg(1, 1, 1, 1, 0, 5)); repeat (3) tick(); #1;
    chk("R9 mode bit no request", int'(dreq_o), 0);
    off(5);

    // R6 zero count never requests
    wr(1, 16'd0);
    wr(0, mkcfg(0, 1, 1, 1, 0, 5)); tick(); tick(); #1;
    chk("R6 zero count no request", int'(dreq_o), 0);
    off(5);

    // R7 short and empty packet termination
    wr(1, 16'd100);
    wr(0, mkcfg(0, 1, 1, 1, 3, 5)); tick();
    short_pkt_i = 1'b1; tick(); short_pkt_i = 1'b0; #1;
    chk("R7 short gives eot", int'(eot_o), 1);
    rd(2, v); chk("R7 short status bit", v, 2);
    rd(0, v); chk("R7 short clears enable", v & 16'h40, 0);
    tick(); #1;
    chk("R7 eot one cycle", int'(eot_o), 0);
    chk("R7 request dropped", int'(dreq_o), 0);
    rd(1, v); chk("R7 count untouched", v, 100);
    wr(2, 16'h2);
    wr(0, mkcfg(0, 1, 1, 1, 3, 5)); tick();
    empty_pkt_i = 1'b1; tick(); empty_pkt_i = 1'b0; #1;
    chk("R7 empty gives eot", int'(eot_o), 1);
    rd(2, v); chk("R7 empty status bit", v, 4);
    wr(2, 16'h4);
    empty_pkt_i = 1'b1; short_pkt_i = 1'b1; tick();
    empty_pkt_i = 1'b0; short_pkt_i = 1'b0; #1;
    chk("R7 ignored while disabled", int'(eot_o), 0);
    rd(2, v); chk("R7 status untouched while disabled", v, 0);

    // R10 write-1-clear against same-cycle set
    ep_data_avail_i[5] = 1'b0; ep_dir_i[5] = 1'b0;
    wr(0, mkcfg(0, 1, 1, 1, 0, 5));
    short_pkt_i = 1'b1; wr(2, 16'h2); short_pkt_i = 1'b0;
    rd(2, v); chk("R10 set wins over clear", v, 2);
    wr(2, 16'h2);
    rd(2, v); chk("R10 plain clear", v, 0);
    wr(0, mkcfg(0, 1, 1, 1, 0, 5));
    short_pkt_i = 1'b1; empty_pkt_i = 1'b1; tick();
    short_pkt_i = 1'b0; empty_pkt_i = 1'b0;
    rd(2, v); chk("R7 both causes", v, 6);
    wr(2, 16'h4);
    rd(2, v); chk("R10 only written bits cleared", v, 2);
    wr(2, 16'h2);

    // R11 count write against acknowledged byte
    ep_data_avail_i[5] = 1'b1;
    wr(1, 16'd20);
    wr(0, mkcfg(0, 1, 1, 1, 3, 5)); tick(); #1;
    chk("R11 request up", int'(dreq_o), 1);
    dack_i = 1'b1; wr(1, 16'd50); dack_i = 1'b0;
    rd(1, v); chk("R11 load wins", v, 50);
    dack_i = 1'b1; tick(); dack_i = 1'b0;
    rd(1, v); chk("R11 decrement after load", v, 49);
    off(5); tick();

    // R5 R6 directed corners then random transfers
    run_xfer(7, 1'b0, 3, 40, 1'b1, 1'b1);
    run_xfer(14, 1'b1, 0, 1, 1'b0, 1'b1);
    run_xfer(2, 1'b1, 2, 8, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      run_xfer(2 + int'($urandom % 14), 1'($urandom), int'($urandom % 4),
               1 + int'($urandom % 40), 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule